// File: doc/BRIEF.md
# Square Matrix Product Engine

This block multiplies two N-by-N matrices of signed integers, C = A × B, one product per clock. All three matrices live in a single flat, word-addressed memory, each stored row-major from its own base address, so element (I,J) of any operand sits at its base plus I·N + J. A one-cycle `start` pulse latches the size N and the three base addresses. The engine then produces the output elements in row order and, within a row, in column order.

For each output element the engine clears a private running sum and streams N element pairs out of A and B through two read ports. Each read port returns its data one cycle after the request. The engine folds each product into the sum and writes the finished sum to C through a write port. The sum is never read back from C.

Operand addresses are produced by adders alone. The A index starts at the row base I·N and steps by 1. The B index starts at J and steps by N. The row base itself grows by N on each new row. When the last result has been written, the engine pulses `done` and returns to idle.

Top module: `mm_engine`

## Requirements
- R1: During and right after reset, `busy`, `done`, `a_rd_en`, `b_rd_en` and `c_wr_en` are all 0.
- R2: Results are written in row-then-column order. Element (I,J) goes to `base_c + I·N + J`, so consecutive writes in a run go to consecutive addresses starting at `base_c`.
- R3: For element (I,J) and step K (0 ≤ K < N), the A read address is `base_a + I·N + K` and the B read address is `base_b + K·N + J`. The order is I outermost, then J, with K innermost.
- R4: Each written word is the exact signed sum over K of A[I][K]·B[K][J]. Operands are W-bit two's complement, taken from the low W bits of the read data. The result is 2·W + ceil(log2 NMAX) bits wide, so no overflow occurs, even when every operand is the most negative value.
- R5: The running sum restarts from zero for every output element, so no part of one element's sum leaks into the next.
- R6: Reads are issued on every cycle of a run with no gaps. `done` is high in the cycle that follows N³+2 rising edges after the edge that accepted `start`.
- R7: `start` is ignored while `busy` is high, and also when `n_size` is 0 or greater than NMAX. An ignored start changes neither the running computation nor any memory word.
- R8: `done` is high for exactly one cycle. That cycle immediately follows the cycle of the final C write, and in it `busy` is already 0.
- R9: With N = 1 the engine performs exactly one read on each read port and exactly one write.
- R10: `a_rd_en` and `b_rd_en` are always equal. A run makes exactly N³ reads on each port and exactly N² writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; sampled only when idle |
| n_size | input | NW | Matrix dimension N, 1..NMAX |
| base_a | input | AW | Word address of A[0][0] |
| base_b | input | AW | Word address of B[0][0] |
| base_c | input | AW | Word address of C[0][0] |
| a_rd_en | output | 1 | A read request |
| a_rd_addr | output | AW | A read address |
| a_rd_data | input | W | A read data, one cycle after the request |
| b_rd_en | output | 1 | B read request |
| b_rd_addr | output | AW | B read address |
| b_rd_data | input | W | B read data, one cycle after the request |
| c_wr_en | output | 1 | C write strobe |
| c_wr_addr | output | AW | C write address |
| c_wr_data | output | ACCW | C write data (signed sum) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Two things can happen in the same cycle. The sum for one output element may be completed and captured for writing, while the first product of the next element is being folded into a freshly cleared sum. The bench provokes this on every element boundary, across many random sizes. N = 1 is the sharpest case, because there every product is both the first and the last of its element. Any mix-up between clearing and finishing shows up as a wrong C word, and each C word is compared against a sum the bench computes from its own copy of the operands.

// File: rtl/mm_pkg.sv
package mm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } eng_state_t;

    // control tag that travels with each issued read pair
    typedef struct packed {
        logic valid;   // a read pair was issued
        logic first;   // K == 0 for this element
        logic last;    // K == N-1 for this element
        logic fin;     // last K of the last element of the run
    } step_ctl_t;

    // accumulator width that cannot overflow for NMAX products of W-bit operands
    function automatic int acc_bits(input int w, input int nmax);
        return 2 * w + $clog2(nmax);
    endfunction

endpackage

// File: rtl/mm_addr_gen.sv
module mm_addr_gen #(
    parameter int NW = 4,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [NW-1:0] n,
    output logic [AW-1:0] a_idx,
    output logic [AW-1:0] b_idx,
    output logic [AW-1:0] c_off,
    output logic          k_first,
    output logic          k_last,
    output logic          run_last
);
    logic [NW-1:0] i_q, j_q, k_q;
    logic [AW-1:0] row_q, a_q, b_q;
    logic [NW-1:0] nm1;
    logic [AW-1:0] n_ext;
    logic          j_last, i_last;

    assign nm1    = n - NW'(1);
    assign n_ext  = AW'(n);
    assign j_last = (j_q == nm1);
    assign i_last = (i_q == nm1);

    assign k_first  = (k_q == '0);
    assign k_last   = (k_q == nm1);
    assign run_last = k_last && j_last && i_last;
    assign a_idx    = a_q;
    assign b_idx    = b_q;
    assign c_off    = row_q + AW'(j_q);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            i_q   <= '0;
            j_q   <= '0;
            k_q   <= '0;
            row_q <= '0;
            a_q   <= '0;
            b_q   <= '0;
        end else if (step) begin
            if (!k_last) begin
                k_q <= k_q + NW'(1);
                a_q <= a_q + AW'(1);
                b_q <= b_q + n_ext;
            end else if (!j_last) begin
                k_q <= '0;
                j_q <= j_q + NW'(1);
                a_q <= row_q;
                b_q <= AW'(j_q) + AW'(1);
            end else begin
                k_q   <= '0;
                j_q   <= '0;
                i_q   <= i_q + NW'(1);
                row_q <= row_q + n_ext;
                a_q   <= row_q + n_ext;
                b_q   <= '0;
            end
        end
    end
endmodule

// File: rtl/mm_mac.sv
module mm_mac
    import mm_pkg::*;
#(
    parameter int W    = 8,
    parameter int AW   = 10,
    parameter int ACCW = 19
) (
    input  logic                   clk,
    input  logic                   rst,
    input  step_ctl_t              ctl_in,
    input  logic [AW-1:0]          addr_in,
    input  logic signed [W-1:0]    a_in,
    input  logic signed [W-1:0]    b_in,
    output logic                   wr_en,
    output logic [AW-1:0]          wr_addr,
    output logic [ACCW-1:0]        wr_data,
    output logic                   wr_fin
);
    step_ctl_t                ctl_q;
    logic [AW-1:0]            addr_q;
    logic signed [ACCW-1:0]   acc_q;
    logic signed [2*W-1:0]    prod;
    logic signed [ACCW-1:0]   prod_ext;
    logic signed [ACCW-1:0]   sum_base;
    logic signed [ACCW-1:0]   sum_next;

    // operand data arrives one cycle after issue, aligned with ctl_q
    assign prod     = a_in * b_in;
    assign prod_ext = {{(ACCW-2*W){prod[2*W-1]}}, prod};
    assign sum_base = ctl_q.first ? '0 : acc_q;
    assign sum_next = sum_base + prod_ext;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '0;
            addr_q  <= '0;
            acc_q   <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            wr_fin  <= 1'b0;
        end else begin
            ctl_q  <= ctl_in;
            addr_q <= addr_in;
            wr_en  <= ctl_q.valid && ctl_q.last;
            wr_fin <= ctl_q.valid && ctl_q.fin;
            if (ctl_q.valid) begin
                acc_q <= sum_next;
            end
            if (ctl_q.valid && ctl_q.last) begin
                wr_addr <= addr_q;
                wr_data <= sum_next;
            end
        end
    end
endmodule

// File: rtl/mm_engine.sv
module mm_engine
    import mm_pkg::*;
#(
    parameter  int W    = 8,
    parameter  int NMAX = 8,    // at least 2
    parameter  int AW   = 10,
    localparam int NW   = $clog2(NMAX + 1),
    localparam int ACCW = acc_bits(W, NMAX)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [NW-1:0]   n_size,
    input  logic [AW-1:0]   base_a,
    input  logic [AW-1:0]   base_b,
    input  logic [AW-1:0]   base_c,
    output logic            a_rd_en,
    output logic [AW-1:0]   a_rd_addr,
    input  logic [W-1:0]    a_rd_data,
    output logic            b_rd_en,
    output logic [AW-1:0]   b_rd_addr,
    input  logic [W-1:0]    b_rd_data,
    output logic            c_wr_en,
    output logic [AW-1:0]   c_wr_addr,
    output logic [ACCW-1:0] c_wr_data,
    output logic            busy,
    output logic            done
);
    eng_state_t    state_q;
    logic [NW-1:0] n_q;
    logic [AW-1:0] ba_q, bb_q, bc_q;
    logic          accept, issue;
    logic [AW-1:0] a_idx, b_idx, c_off;
    logic          k_first, k_last, run_last, wr_fin;
    step_ctl_t     ctl_issue;

    assign accept = start && (state_q == ST_IDLE) && (n_size != '0)
                    && (n_size <= NW'(NMAX));
    assign issue  = (state_q == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done    <= 1'b0;
            n_q     <= '0;
            ba_q    <= '0;
            bb_q    <= '0;
            bc_q    <= '0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: if (accept) begin
                    state_q <= ST_RUN;
                    n_q     <= n_size;
                    ba_q    <= base_a;
                    bb_q    <= base_b;
                    bc_q    <= base_c;
                end
                ST_RUN: if (run_last) state_q <= ST_DRAIN;
                ST_DRAIN: if (wr_fin) begin
                    state_q <= ST_IDLE;
                    done    <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    mm_addr_gen #(.NW(NW), .AW(AW)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .step     (issue),
        .n        (n_q),
        .a_idx    (a_idx),
        .b_idx    (b_idx),
        .c_off    (c_off),
        .k_first  (k_first),
        .k_last   (k_last),
        .run_last (run_last)
    );

    assign ctl_issue = '{valid: issue, first: k_first, last: k_last, fin: run_last};

    mm_mac #(.W(W), .AW(AW), .ACCW(ACCW)) u_mac (
        .clk     (clk),
        .rst     (rst),
        .ctl_in  (ctl_issue),
        .addr_in (bc_q + c_off),
        .a_in    (a_rd_data),
        .b_in    (b_rd_data),
        .wr_en   (c_wr_en),
        .wr_addr (c_wr_addr),
        .wr_data (c_wr_data),
        .wr_fin  (wr_fin)
    );

    assign a_rd_en   = issue;
    assign b_rd_en   = issue;
    assign a_rd_addr = ba_q + a_idx;
    assign b_rd_addr = bb_q + b_idx;
    assign busy      = (state_q != ST_IDLE);
endmodule

// File: rtl/mm_engine_chk.sv
module mm_engine_chk #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          done,
    input logic          a_rd_en,
    input logic          b_rd_en,
    input logic          c_wr_en,
    input logic [AW-1:0] c_wr_addr
);
    logic          seen_q;
    logic [AW-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst || done) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (c_wr_en) begin
            seen_q <= 1'b1;
            last_q <= c_wr_addr;
        end
    end

    a_r10_rd_paired: assert property (@(posedge clk) disable iff (rst)
        a_rd_en == b_rd_en);

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_done_after_write: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(c_wr_en));

    a_r8_idle_at_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r6_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!a_rd_en && !c_wr_en));

    a_r2_write_ascending: assert property (@(posedge clk) disable iff (rst)
        (c_wr_en && seen_q) |-> (c_wr_addr == last_q + AW'(1)));
endmodule

bind mm_engine mm_engine_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_mm_engine.sv
`timescale 1ns/1ps
module sim_mm_engine;
    localparam int W    = 8;
    localparam int NMAX = 8;
    localparam int AW   = 10;
    localparam int NW   = $clog2(NMAX + 1);
    localparam int ACCW = 2 * W + $clog2(NMAX);
    localparam int MEMD = 1 << AW;
    localparam logic [ACCW-1:0] SENT = ACCW'(19'h5A5A5);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [NW-1:0]   n_size = '0;
    logic [AW-1:0]   base_a = '0, base_b = '0, base_c = '0;
    logic            a_rd_en, b_rd_en, c_wr_en, busy, done;
    logic [AW-1:0]   a_rd_addr, b_rd_addr, c_wr_addr;
    logic [W-1:0]    a_rd_data, b_rd_data;
    logic [ACCW-1:0] c_wr_data;

    logic [ACCW-1:0] mem [MEMD];
    int ea [64];
    int eb [64];
    int checks = 0, errs = 0;
    int rd_cnt = 0, wcnt = 0, addr_err = 0;
    int tn = 1, tba = 0, tbb = 0;
    int wlog [64];

    always #10 clk = ~clk;

    mm_engine #(.W(W), .NMAX(NMAX), .AW(AW)) u0 (.*);

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        a_rd_data <= mem[a_rd_addr][W-1:0];
        b_rd_data <= mem[b_rd_addr][W-1:0];
        if (c_wr_en) mem[c_wr_addr] <= c_wr_data;
    end

    // request monitor against the expected walk order
    always @(posedge clk) begin
        if (a_rd_en || b_rd_en) begin
            int i, j, k;
            i = rd_cnt / (tn * tn);
            j = (rd_cnt / tn) % tn;
            k = rd_cnt % tn;
            if (a_rd_en !== b_rd_en) addr_err++;
            if (int'(a_rd_addr) != tba + i * tn + k) addr_err++;
            if (int'(b_rd_addr) != tbb + k * tn + j) addr_err++;
            rd_cnt++;
        end
        if (c_wr_en) begin
            if (wcnt < 64) wlog[wcnt] = int'(c_wr_addr);
            wcnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_elem(input int n, input int i, input int j);
        int s = 0;
        for (int k = 0; k < n; k++) s += ea[i * n + k] * eb[k * n + j];
        return s;
    endfunction

    function automatic int rnd_op();
        return int'($urandom_range(0, 255)) - 128;
    endfunction

    task automatic put(input int addr, input int v);
        logic [W-1:0] b;
        b = W'(v);
        mem[addr] = {{(ACCW-W){1'b0}}, b};
    endtask

    // mode 0 random, 1 all most-negative
    task automatic run_mm(input int n, input int ba, input int bb, input int bc,
                          input bit poke, input int mode);
        int cyc;
        int pbc;
        pbc = 900;
        for (int x = 0; x < n * n; x++) begin
            ea[x] = (mode == 1) ? -128 : rnd_op();
            eb[x] = (mode == 1) ? -128 : rnd_op();
            put(ba + x, ea[x]);
            put(bb + x, eb[x]);
            mem[bc + x] = SENT;
        end
        for (int x = 0; x < 64; x++) mem[pbc + x] = SENT;
        rd_cnt = 0; wcnt = 0; addr_err = 0;
        tn = n; tba = ba; tbb = bb;
        @(negedge clk);
        start  = 1'b1;
        n_size = NW'(n);
        base_a = AW'(ba);
        base_b = AW'(bb);
        base_c = AW'(bc);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 5000) begin
            if (poke && cyc == 2) begin
                start  = 1'b1;
                n_size = NW'(2);
                base_c = AW'(pbc);
            end
            if (poke && cyc == 3) start = 1'b0;
            @(negedge clk);
            cyc++;
        end
        chk(done === 1'b1, "R6 done seen", cyc, n * n * n + 2);
        chk(cyc == n * n * n + 2, "R6 run length", cyc, n * n * n + 2);
        chk(rd_cnt == n * n * n, "R10 read count", rd_cnt, n * n * n);
        chk(addr_err == 0, "R3 read addresses", addr_err, 0);
        chk(wcnt == n * n, "R10 write count", wcnt, n * n);
        if (n == 1) chk(rd_cnt == 1 && wcnt == 1, "R9 single op", rd_cnt + wcnt, 2);
        for (int x = 0; x < n * n && x < 64; x++)
            chk(wlog[x] == bc + x, "R2 write order", wlog[x], bc + x);
        for (int i = 0; i < n; i++) begin
            for (int j = 0; j < n; j++) begin
                int got;
                got = int'($signed(mem[bc + i * n + j]));
                chk(got == exp_elem(n, i, j), "R4 R5 element value", got, exp_elem(n, i, j));
            end
        end
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R8 done pulse then idle",
            int'({done, busy}), 0);
        if (poke) begin
            int bad = 0;
            for (int x = 0; x < 64; x++) if (mem[pbc + x] !== SENT) bad++;
            chk(bad == 0, "R7 start while busy ignored", bad, 0);
        end
    endtask

    initial begin
        #(200000 * 20);
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int x = 0; x < MEMD; x++) mem[x] = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !a_rd_en && !c_wr_en, "R1 state in reset",
            int'({busy, done, a_rd_en, c_wr_en}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !a_rd_en && !b_rd_en && !c_wr_en, "R1 state after reset",
            int'({busy, done, a_rd_en, b_rd_en, c_wr_en}), 0);

        run_mm(1, 10, 300, 600, 1'b0, 0);        // R9
        run_mm(1, 11, 301, 601, 1'b0, 1);        // R9 with extreme operands
        run_mm(2, 20, 320, 620, 1'b0, 0);
        run_mm(3, 30, 330, 630, 1'b0, 0);
        run_mm(NMAX, 0, 200, 500, 1'b0, 1);      // R4 worst-case magnitude
        run_mm(4, 40, 340, 640, 1'b1, 0);        // R7 start while busy

        // R7: size 0 and size above NMAX are refused
        for (int t = 0; t < 2; t++) begin
            int bsy = 0;
            @(negedge clk);
            start  = 1'b1;
            n_size = (t == 0) ? NW'(0) : NW'(NMAX + 1);
            base_c = AW'(900);
            @(negedge clk);
            start = 1'b0;
            repeat (4) begin
                if (busy || a_rd_en || c_wr_en) bsy++;
                @(negedge clk);
            end
            chk(bsy == 0, "R7 bad size ignored", bsy, 0);
        end

        for (int r = 0; r < 6; r++) begin
            int n;
            n = int'($urandom_range(1, NMAX));
            run_mm(n, int'($urandom_range(0, 100)), 200 + int'($urandom_range(0, 100)),
                   400 + int'($urandom_range(0, 100)), 1'b0, 0);
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule